// File: doc/BRIEF.md
# Shared-Opcode Instruction Decoder

This block turns one 8-bit instruction byte into the control fields that a small accumulator-less processor needs. The upper four bits carry an operation code and the lower four bits hold two 2-bit register selectors: a destination field in bits 3:2 and a source field in bits 1:0. Several operation codes are shared between instructions. A register selector of value zero stands for "no register given", and that choice changes what the code means. The same opcode can therefore mean a jump, an ALU operation, a load form or a no-op.

The decoder is purely combinational. It reports an instruction class twice: as a 5-bit code and as a one-hot vector. It also reports whether a second instruction word (a constant or an address) follows, the ALU function to apply, the jump condition to test, and both register selectors. The register file, the ALU and the fetch/execute sequencer sit outside the block and use these outputs in the same cycle.

Top module: `shared_op_decoder`

## Requirements
- R1: `rd_idx_o` always equals instruction bits 3:2 and `rs_idx_o` always equals bits 1:0, whatever the opcode.
- R2: Opcode 0000 decodes as NOP when both selectors are zero, as direct load when only the source selector is zero, and as indirect load whenever the source selector is nonzero.
- R3: Opcode 0001 decodes as direct store when the destination selector is zero, and as indirect store otherwise.
- R4: Opcode 0010 decodes as load-constant when the source selector is zero, and as register move otherwise.
- R5: Opcodes 0100, 0101 and 0110 decode as jumps (always, on overflow, on negative) when both selectors are zero, and otherwise as compare, add-with-carry and subtract-with-borrow. A jump condition other than none appears exactly when the class is jump.
- R6: Opcode 1000 is jump-on-zero when both selectors are zero and AND otherwise; 1001 is always OR and 1010 is always XOR.
- R7: Opcode 1100 is jump-on-carry when the destination selector is zero and rotate-left otherwise; 1101 is clear-carry when the destination selector is zero and rotate-right otherwise. The source selector has no effect on either choice.
- R8: Opcode 1110 is set-carry and 1111 is halt, for any selector values.
- R9: Opcodes 0011, 0111 and 1011 decode as NOP with no second word, for any selector values.
- R10: `two_word_o` is high exactly for load-constant, direct load, direct store and every jump.
- R11: `cls_onehot_o` has exactly one bit set, at the position given by `cls_o`.
- R12: Class codes on `cls_o` are NOP 0, load-constant 1, direct load 2, indirect load 3, direct store 4, indirect store 5, move 6, set-carry 7, clear-carry 8, add-with-carry 9, subtract-with-borrow 10, compare 11, AND 12, OR 13, XOR 14, rotate-left 15, rotate-right 16, jump 17, halt 18.
- R13: `alu_fn_o` is add 1 for add-with-carry, subtract 2 for subtract-with-borrow and compare, AND 3, OR 4, XOR 5, rotate-left 6, rotate-right 7, and 0 for every other class. `jcond_o` is none 0, always 1, carry 2, overflow 3, negative 4, zero 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 8 | Instruction byte: opcode 7:4, destination selector 3:2, source selector 1:0 |
| cls_o | output | 5 | Instruction class code |
| cls_onehot_o | output | 19 | Instruction class as a one-hot vector |
| two_word_o | output | 1 | A second instruction word follows |
| alu_fn_o | output | 3 | ALU function select |
| jcond_o | output | 3 | Jump condition select |
| rd_idx_o | output | 2 | Destination register selector |
| rs_idx_o | output | 2 | Source register selector |

## Verification
The block holds no state, so a wrong internal decision is visible at the ports in the same cycle as the instruction that causes it. A zero detector that misfires shows as the wrong class of a shared opcode. A bad class-to-control map shows as an ALU select, second-word flag or one-hot bit that disagrees with the class code. The bench drives every one of the 256 instruction bytes, after a directed set that targets each zero/nonzero boundary, so every mix-up between shared meanings reaches a compared output.

// File: rtl/sod_pkg.sv
package sod_pkg;

   localparam int NUM_CLS = 19;
   localparam int CLS_W   = $clog2(NUM_CLS);

   typedef enum logic [CLS_W-1:0] {
      CLS_NOP  = 5'd0,
      CLS_LDC  = 5'd1,
      CLS_LDD  = 5'd2,
      CLS_LDI  = 5'd3,
      CLS_STD  = 5'd4,
      CLS_STI  = 5'd5,
      CLS_MOV  = 5'd6,
      CLS_SETC = 5'd7,
      CLS_CLRC = 5'd8,
      CLS_ADC  = 5'd9,
      CLS_SBC  = 5'd10,
      CLS_CMP  = 5'd11,
      CLS_AND  = 5'd12,
      CLS_OR   = 5'd13,
      CLS_XOR  = 5'd14,
      CLS_ROL  = 5'd15,
      CLS_ROR  = 5'd16,
      CLS_JMP  = 5'd17,
      CLS_HALT = 5'd18
   } cls_e;

   typedef enum logic [2:0] {
      ALU_NONE = 3'd0,
      ALU_ADD  = 3'd1,
      ALU_SUB  = 3'd2,
      ALU_AND  = 3'd3,
      ALU_OR   = 3'd4,
      ALU_XOR  = 3'd5,
      ALU_ROL  = 3'd6,
      ALU_ROR  = 3'd7
   } alu_e;

   typedef enum logic [2:0] {
      JC_NONE   = 3'd0,
      JC_ALWAYS = 3'd1,
      JC_CARRY  = 3'd2,
      JC_OVF    = 3'd3,
      JC_NEG    = 3'd4,
      JC_ZERO   = 3'd5
   } jcond_e;

endpackage

// File: rtl/sod_field_split.sv
module sod_field_split #(
   parameter int OPC_W = 4,
   parameter int REG_W = 2
) (
   input  logic [OPC_W+2*REG_W-1:0] instr_i,
   output logic [OPC_W-1:0]         opc_o,
   output logic [REG_W-1:0]         rd_o,
   output logic [REG_W-1:0]         rs_o,
   output logic                     rd_zero_o,
   output logic                     rs_zero_o
);
   localparam int NFLD    = 2;
   localparam int INSTR_W = OPC_W + NFLD*REG_W;

   logic [REG_W-1:0] fld  [NFLD];
   logic [NFLD-1:0]  zero;

   // field 0 is the source selector, field 1 the destination selector
   for (genvar g = 0; g < NFLD; g++) begin : g_fld
      assign fld[g]  = instr_i[g*REG_W +: REG_W];
      assign zero[g] = ~|fld[g];
   end

   assign opc_o     = instr_i[INSTR_W-1 -: OPC_W];
   assign rs_o      = fld[0];
   assign rd_o      = fld[1];
   assign rs_zero_o = zero[0];
   assign rd_zero_o = zero[1];

endmodule

// File: rtl/sod_class_sel.sv
module sod_class_sel
   import sod_pkg::*;
#(
   parameter int OPC_W = 4
) (
   input  logic [OPC_W-1:0] opc_i,
   input  logic             rd_zero_i,
   input  logic             rs_zero_i,
   output cls_e             cls_o,
   output jcond_e           jcond_o
);
   logic both_zero;
   assign both_zero = rd_zero_i & rs_zero_i;

   always_comb begin
      cls_o   = CLS_NOP;
      jcond_o = JC_NONE;
      case (opc_i)
         4'h0: begin
            if (!rs_zero_i)     cls_o = CLS_LDI;
            else if (rd_zero_i) cls_o = CLS_NOP;
            else                cls_o = CLS_LDD;
         end
         4'h1: cls_o = rd_zero_i ? CLS_STD : CLS_STI;
         4'h2: cls_o = rs_zero_i ? CLS_LDC : CLS_MOV;
         4'h4: begin
            cls_o = both_zero ? CLS_JMP : CLS_CMP;
            if (both_zero) jcond_o = JC_ALWAYS;
         end
         4'h5: begin
            cls_o = both_zero ? CLS_JMP : CLS_ADC;
            if (both_zero) jcond_o = JC_OVF;
         end
         4'h6: begin
            cls_o = both_zero ? CLS_JMP : CLS_SBC;
            if (both_zero) jcond_o = JC_NEG;
         end
         4'h8: begin
            cls_o = both_zero ? CLS_JMP : CLS_AND;
            if (both_zero) jcond_o = JC_ZERO;
         end
         4'h9: cls_o = CLS_OR;
         4'hA: cls_o = CLS_XOR;
         4'hC: begin
            cls_o = rd_zero_i ? CLS_JMP : CLS_ROL;
            if (rd_zero_i) jcond_o = JC_CARRY;
         end
         4'hD: cls_o = rd_zero_i ? CLS_CLRC : CLS_ROR;
         4'hE: cls_o = CLS_SETC;
         4'hF: cls_o = CLS_HALT;
         default: begin
            cls_o   = CLS_NOP;
            jcond_o = JC_NONE;
         end
      endcase
   end

endmodule

// File: rtl/sod_ctrl_map.sv
module sod_ctrl_map
   import sod_pkg::*;
(
   input  cls_e               cls_i,
   output logic [NUM_CLS-1:0] onehot_o,
   output logic               two_word_o,
   output alu_e               alu_o
);
   for (genvar g = 0; g < NUM_CLS; g++) begin : g_hot
      assign onehot_o[g] = (cls_i == cls_e'(g));
   end

   always_comb begin
      case (cls_i)
         CLS_LDC, CLS_LDD, CLS_STD, CLS_JMP: two_word_o = 1'b1;
         default:                            two_word_o = 1'b0;
      endcase
   end

   always_comb begin
      case (cls_i)
         CLS_ADC:          alu_o = ALU_ADD;
         CLS_SBC, CLS_CMP: alu_o = ALU_SUB;
         CLS_AND:          alu_o = ALU_AND;
         CLS_OR:           alu_o = ALU_OR;
         CLS_XOR:          alu_o = ALU_XOR;
         CLS_ROL:          alu_o = ALU_ROL;
         CLS_ROR:          alu_o = ALU_ROR;
         default:          alu_o = ALU_NONE;
      endcase
   end

endmodule

// File: rtl/shared_op_decoder.sv
module shared_op_decoder
   import sod_pkg::*;
#(
   parameter int OPC_W = 4,
   parameter int REG_W = 2
) (
   input  logic [OPC_W+2*REG_W-1:0] instr_i,
   output logic [CLS_W-1:0]         cls_o,
   output logic [NUM_CLS-1:0]       cls_onehot_o,
   output logic                     two_word_o,
   output logic [2:0]               alu_fn_o,
   output logic [2:0]               jcond_o,
   output logic [REG_W-1:0]         rd_idx_o,
   output logic [REG_W-1:0]         rs_idx_o
);
   localparam int INSTR_W = OPC_W + 2*REG_W;

   if (OPC_W != 4) begin : g_bad_opc
      $error("shared_op_decoder: opcode map needs OPC_W of 4");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("shared_op_decoder: REG_W must be at least 1");
   end
   if (INSTR_W < 6) begin : g_bad_instr
      $error("shared_op_decoder: instruction word too narrow");
   end

   logic [OPC_W-1:0] opc;
   logic [REG_W-1:0] rd, rs;
   logic             rd_zero, rs_zero;
   cls_e             cls;
   jcond_e           jcond;
   alu_e             alu;

   sod_field_split #(.OPC_W(OPC_W), .REG_W(REG_W)) split_i (
      .instr_i   (instr_i),
      .opc_o     (opc),
      .rd_o      (rd),
      .rs_o      (rs),
      .rd_zero_o (rd_zero),
      .rs_zero_o (rs_zero)
   );

   sod_class_sel #(.OPC_W(OPC_W)) sel_i (
      .opc_i     (opc),
      .rd_zero_i (rd_zero),
      .rs_zero_i (rs_zero),
      .cls_o     (cls),
      .jcond_o   (jcond)
   );

   sod_ctrl_map map_i (
      .cls_i      (cls),
      .onehot_o   (cls_onehot_o),
      .two_word_o (two_word_o),
      .alu_o      (alu)
   );

   assign cls_o    = cls;
   assign alu_fn_o = alu;
   assign jcond_o  = jcond;
   assign rd_idx_o = rd;
   assign rs_idx_o = rs;

endmodule

// File: rtl/sod_chk.sv
module sod_chk
   import sod_pkg::*;
(
   input logic [7:0]         instr_i,
   input logic [CLS_W-1:0]   cls_o,
   input logic [NUM_CLS-1:0] cls_onehot_o,
   input logic               two_word_o,
   input logic [2:0]         alu_fn_o,
   input logic [2:0]         jcond_o,
   input logic [1:0]         rd_idx_o,
   input logic [1:0]         rs_idx_o
);
   localparam logic [NUM_CLS-1:0] ONE = 1;

   logic is_jmp, is_alu, is_two, is_undef;

   always_comb begin
      is_jmp   = (cls_o == CLS_JMP);
      is_two   = (cls_o == CLS_LDC) || (cls_o == CLS_LDD) ||
                 (cls_o == CLS_STD) || is_jmp;
      is_alu   = (cls_o >= CLS_ADC) && (cls_o <= CLS_ROR);
      is_undef = (instr_i[7:4] == 4'h3) || (instr_i[7:4] == 4'h7) ||
                 (instr_i[7:4] == 4'hB);
      if (!$isunknown(instr_i)) begin
         // R1
         fields_pass_chk: assert ((rd_idx_o == instr_i[3:2]) && (rs_idx_o == instr_i[1:0]))
            else $error("register selectors do not follow the instruction");
         // R11
         onehot_match_chk: assert (cls_onehot_o == (ONE << cls_o))
            else $error("one-hot class disagrees with class code");
         // R10
         two_word_chk: assert (two_word_o == is_two)
            else $error("second-word flag wrong for class");
         // R5
         jump_cond_chk: assert ((jcond_o != JC_NONE) == is_jmp)
            else $error("jump condition present without jump class");
         // R13
         alu_sel_chk: assert ((alu_fn_o != ALU_NONE) == is_alu)
            else $error("ALU select present on non-ALU class");
         // R9
         undef_nop_chk: assert (!is_undef || (cls_o == CLS_NOP && !two_word_o))
            else $error("unassigned opcode not decoded as NOP");
      end
   end

endmodule

bind shared_op_decoder sod_chk chk_i (
   .instr_i      (instr_i),
   .cls_o        (cls_o),
   .cls_onehot_o (cls_onehot_o),
   .two_word_o   (two_word_o),
   .alu_fn_o     (alu_fn_o),
   .jcond_o      (jcond_o),
   .rd_idx_o     (rd_idx_o),
   .rs_idx_o     (rs_idx_o)
);

// File: tb/shared_op_decoder_tb.sv
module shared_op_decoder_tb_top;

   logic        clk = 1'b0;
   always #2 clk = ~clk;

   logic [7:0]  instr;
   logic [4:0]  cls;
   logic [18:0] onehot;
   logic        two_word;
   logic [2:0]  alu_fn, jcond;
   logic [1:0]  rd_idx, rs_idx;

   shared_op_decoder dut_i (
      .instr_i      (instr),
      .cls_o        (cls),
      .cls_onehot_o (onehot),
      .two_word_o   (two_word),
      .alu_fn_o     (alu_fn),
      .jcond_o      (jcond),
      .rd_idx_o     (rd_idx),
      .rs_idx_o     (rs_idx)
   );

   // class codes per R12
   localparam int C_NOP = 0, C_LDC = 1, C_LDD = 2, C_LDI = 3, C_STD = 4,
                  C_STI = 5, C_MOV = 6, C_SETC = 7, C_CLRC = 8, C_ADC = 9,
                  C_SBC = 10, C_CMP = 11, C_AND = 12, C_OR = 13, C_XOR = 14,
                  C_ROL = 15, C_ROR = 16, C_JMP = 17, C_HALT = 18;

   typedef struct {
      logic [7:0] ins;
      int         cls;
      int         two;
      int         alu;
      int         cond;
      string      tag;
   } item_t;

   item_t sb[$];
   int    checks = 0;
   int    errors = 0;

   function automatic item_t model(logic [7:0] ins);
      item_t e;
      logic  dz, sz;
      dz = (ins[3:2] == 2'b00);
      sz = (ins[1:0] == 2'b00);
      e.ins = ins; e.cls = C_NOP; e.alu = 0; e.cond = 0; e.tag = "R9";
      case (ins[7:4])
         4'h0: begin e.tag = "R2"; e.cls = !sz ? C_LDI : (dz ? C_NOP : C_LDD); end
         4'h1: begin e.tag = "R3"; e.cls = dz ? C_STD : C_STI; end
         4'h2: begin e.tag = "R4"; e.cls = sz ? C_LDC : C_MOV; end
         4'h4: begin e.tag = "R5"; e.cls = (dz && sz) ? C_JMP : C_CMP; e.cond = (dz && sz) ? 1 : 0; end
         4'h5: begin e.tag = "R5"; e.cls = (dz && sz) ? C_JMP : C_ADC; e.cond = (dz && sz) ? 3 : 0; end
         4'h6: begin e.tag = "R5"; e.cls = (dz && sz) ? C_JMP : C_SBC; e.cond = (dz && sz) ? 4 : 0; end
         4'h8: begin e.tag = "R6"; e.cls = (dz && sz) ? C_JMP : C_AND; e.cond = (dz && sz) ? 5 : 0; end
         4'h9: begin e.tag = "R6"; e.cls = C_OR; end
         4'hA: begin e.tag = "R6"; e.cls = C_XOR; end
         4'hC: begin e.tag = "R7"; e.cls = dz ? C_JMP : C_ROL; e.cond = dz ? 2 : 0; end
         4'hD: begin e.tag = "R7"; e.cls = dz ? C_CLRC : C_ROR; end
         4'hE: begin e.tag = "R8"; e.cls = C_SETC; end
         4'hF: begin e.tag = "R8"; e.cls = C_HALT; end
         default: begin e.tag = "R9"; e.cls = C_NOP; end
      endcase
      // ALU selects per R13
      case (e.cls)
         C_ADC:        e.alu = 1;
         C_SBC, C_CMP: e.alu = 2;
         C_AND:        e.alu = 3;
         C_OR:         e.alu = 4;
         C_XOR:        e.alu = 5;
         C_ROL:        e.alu = 6;
         C_ROR:        e.alu = 7;
         default:      e.alu = 0;
      endcase
      // second word per R10
      e.two = (e.cls == C_LDC || e.cls == C_LDD || e.cls == C_STD || e.cls == C_JMP) ? 1 : 0;
      return e;
   endfunction

   task automatic chk(string tag, logic [7:0] ins, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s instr=%02h actual=%0d expected=%0d", tag, ins, act, exp);
      end
   endtask

   task automatic drive(logic [7:0] ins);
      @(negedge clk);
      instr = ins;
      sb.push_back(model(ins));
   endtask

   // monitor: compares one scoreboard item per cycle, 1 ns after the rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            chk({it.tag, " class R12"}, it.ins, int'(cls), it.cls);
            chk("R10 second word", it.ins, int'(two_word), it.two);
            chk("R13 alu select", it.ins, int'(alu_fn), it.alu);
            chk({it.tag, " R13 jump cond"}, it.ins, int'(jcond), it.cond);
            chk("R11 one-hot", it.ins, int'(onehot), 1 << it.cls);
            chk("R1 rd field", it.ins, int'(rd_idx), int'(it.ins[3:2]));
            chk("R1 rs field", it.ins, int'(rs_idx), int'(it.ins[1:0]));
         end
      end
   end

   initial begin
      instr = 8'h00;
      // first item: the all-zero byte, the idle value after reset (R2)
      drive(8'h00);
      // zero/nonzero selector boundaries of every shared opcode
      drive(8'h08); drive(8'h09); drive(8'h01);                 // R2
      drive(8'h10); drive(8'h1B); drive(8'h14);                 // R3
      drive(8'h20); drive(8'h26); drive(8'h2C);                 // R4
      drive(8'h40); drive(8'h43); drive(8'h50); drive(8'h5C);   // R5
      drive(8'h60); drive(8'h61);                               // R5
      drive(8'h80); drive(8'h81); drive(8'h90); drive(8'hA5);   // R6
      drive(8'hC0); drive(8'hC3); drive(8'hC4);                 // R7
      drive(8'hD0); drive(8'hD2); drive(8'hD8);                 // R7
      drive(8'hE0); drive(8'hEF); drive(8'hF7);                 // R8
      drive(8'h30); drive(8'h7F); drive(8'hB4);                 // R9
      // full sweep of every byte
      for (int i = 0; i < 256; i++) drive(8'(i));
      wait (sb.size() == 0);
      @(posedge clk);
      #3;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // watchdog
   initial begin
      #(4 * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule